// File: doc/BRIEF.md
# Sequencer Debug Breakpoint Unit

This block watches a small microcoded sequencer and stops it when a debug condition that has been switched on occurs. It compares the sequencer's microprogram counter against a programmed breakpoint address. It compares the channel register against a programmed channel value. It also samples four service and status latches at each state boundary. When any enabled condition fires, the unit asserts a breakpoint output and a halt request. It also records which kind of condition caused the stop. The breakpoint stays asserted until a host acknowledge or a freeze request arrives.

A freeze request halts the sequencer on its own and sets a separate flag. That flag follows the freeze input and clears by itself once freeze drops. Software programs three registers through a simple select, write and read port: the enables, the address breakpoint and the channel breakpoint. It observes the cause flags in a read-only status register.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset, every readable register reads zero, and `bkpt_out` and `halt_req` are low.
- R2: Select 0 is the enable register: its bits [5:0] are writable and its other bits read 0. Select 1 is the address breakpoint and select 2 is the channel breakpoint; each reads back what was written. Select 3 is the status register, and a write to it changes no register. Status bit 7 is breakpoint, bit 6 is address cause, bit 5 is channel cause, bit 4 is service cause and bit 3 is freeze. All its other bits read 0.
- R3: When enable bit 5 is set and `seq_upc` equals the address breakpoint in a cycle with `state_start` high, then after that clock edge `bkpt_out`, `halt_req`, status bit 7 and status bit 6 are high. The same address match with `state_start` low starts no breakpoint.
- R4: With enable bit 4 set, the channel condition fires in either of two cases. The first is `state_start` high with `seq_chan` equal to the channel breakpoint. The second is `chan_wr` high with `chan_wdata` equal to the channel breakpoint, whether or not `state_start` is high. Either case sets status bits 7 and 5.
- R5: `svc_lat` bits [3:0] pair with enable bits [3:0]: host service, link service, match recognition and transition detect. A latch that is high while its enable is set fires only in a cycle with `state_start` high, and it sets status bits 7 and 4.
- R6: A condition whose enable bit is clear never starts a breakpoint or sets a cause flag.
- R7: When several enabled conditions fire in the same cycle, every matching cause flag is set together.
- R8: While the breakpoint is asserted and neither `bkpt_ack` nor `freeze` is high, the breakpoint and cause flags hold their values. Further conditions add no cause flag.
- R9: `bkpt_ack` high while the breakpoint is asserted clears the breakpoint and all three cause flags at the next edge, and `halt_req` then drops.
- R10: `freeze` high clears the breakpoint and the cause flags, sets status bit 3 and `halt_req` at the next edge, and blocks new breakpoints. Status bit 3 clears one edge after `freeze` falls.
- R11: `halt_req` is high exactly when the breakpoint flag or the freeze flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 enables, 1 address bp, 2 channel bp, 3 status) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| state_start | input | 1 | Marks the first cycle of a sequencer state |
| seq_upc | input | UPC_W | Sequencer microprogram counter |
| seq_chan | input | CH_W | Sequencer channel register |
| chan_wr | input | 1 | Microcode is writing a new channel value |
| chan_wdata | input | CH_W | Channel value being written |
| svc_lat | input | 4 | Host, link, match and transition latches (bits 3 to 0) |
| bkpt_ack | input | 1 | Host breakpoint acknowledge |
| freeze | input | 1 | Freeze request |
| bkpt_out | output | 1 | Breakpoint asserted |
| halt_req | output | 1 | Halt request to the sequencer |

## Verification
The assertions check on every cycle that a held breakpoint keeps its cause flags and that acknowledge or freeze clears them. They also check that a cause flag only rises together with the breakpoint flag and only when its enable bit was set, and that freeze always forces a halt without a breakpoint. The bench scenarios are needed for the rest. They show the mid-state channel compare on a microcode write, and that latches are ignored away from a state boundary. They also cover the bit layout of the status word, the read-back of the masked enable register, and the order in which freeze, acknowledge and new conditions are resolved against a reference model.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_UBP  = 2'd1,
    SEL_CBP  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int EN_W    = 6;
  localparam int EN_UPC  = 5;
  localparam int EN_CHAN = 4;
  localparam int LAT_W   = 4;
  localparam int STAT_W  = 5;
  localparam int STAT_LO = 3;

  typedef struct packed {
    logic upc;
    logic chan;
    logic svc;
  } cause_t;

endpackage

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
  import dbg_bp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int UPC_W = 10,
  parameter int CH_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [STAT_W-1:0] stat_flags,
  output logic [EN_W-1:0]   ctrl_q,
  output logic [UPC_W-1:0]  ubp_q,
  output logic [CH_W-1:0]   cbp_q,
  output logic [DW-1:0]     reg_rdata
);

  reg_sel_e        sel;
  logic            ctrl_en, ubp_en, cbp_en;
  logic [EN_W-1:0] ctrl_d;
  logic [UPC_W-1:0] ubp_d;
  logic [CH_W-1:0] cbp_d;

  always_comb begin
    sel     = reg_sel_e'(reg_sel);
    ctrl_en = reg_wr && (sel == SEL_CTRL);
    ubp_en  = reg_wr && (sel == SEL_UBP);
    cbp_en  = reg_wr && (sel == SEL_CBP);
    ctrl_d  = reg_wdata[EN_W-1:0];
    ubp_d   = reg_wdata[UPC_W-1:0];
    cbp_d   = reg_wdata[CH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ubp_q  <= '0;
      cbp_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (ubp_en)  ubp_q  <= ubp_d;
      if (cbp_en)  cbp_q  <= cbp_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CTRL: reg_rdata[EN_W-1:0]  = ctrl_q;
      SEL_UBP:  reg_rdata[UPC_W-1:0] = ubp_q;
      SEL_CBP:  reg_rdata[CH_W-1:0]  = cbp_q;
      default:  reg_rdata[STAT_LO +: STAT_W] = stat_flags;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  // R2
  stat_wr_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3) |=> ($stable(ctrl_q) && $stable(ubp_q) && $stable(cbp_q)));

endmodule

// File: rtl/dbg_bp_detect.sv
module dbg_bp_detect
  import dbg_bp_pkg::*;
#(
  parameter int UPC_W = 10,
  parameter int CH_W  = 4
) (
  input  logic [EN_W-1:0]  ctrl_q,
  input  logic [UPC_W-1:0] ubp_q,
  input  logic [CH_W-1:0]  cbp_q,
  input  logic             state_start,
  input  logic [UPC_W-1:0] seq_upc,
  input  logic [CH_W-1:0]  seq_chan,
  input  logic             chan_wr,
  input  logic [CH_W-1:0]  chan_wdata,
  input  logic [LAT_W-1:0] svc_lat,
  output cause_t           hits
);

  logic [LAT_W-1:0] lat_hit;

  // one enable/latch pair per service source
  for (genvar g = 0; g < LAT_W; g++) begin : g_lat
    assign lat_hit[g] = state_start && ctrl_q[g] && svc_lat[g];
  end

  always_comb begin
    hits.upc  = state_start && ctrl_q[EN_UPC] && (seq_upc == ubp_q);
    hits.chan = ctrl_q[EN_CHAN] &&
                ((state_start && (seq_chan == cbp_q)) ||
                 (chan_wr && (chan_wdata == cbp_q)));
    hits.svc  = |lat_hit;
  end

endmodule

// File: rtl/dbg_bp_status.sv
module dbg_bp_status
  import dbg_bp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t hits,
  input  logic   bkpt_ack,
  input  logic   freeze,
  output logic   bkpt_q,
  output cause_t cause_q,
  output logic   frz_q
);

  logic   bkpt_d;
  cause_t cause_d;
  logic   flag_en;
  logic   any_hit;

  always_comb begin
    any_hit = hits.upc | hits.chan | hits.svc;
    flag_en = freeze | (bkpt_q & bkpt_ack) | (~bkpt_q & any_hit);
    bkpt_d  = bkpt_q;
    cause_d = cause_q;
    if (freeze) begin
      bkpt_d  = 1'b0;
      cause_d = '0;
    end else if (bkpt_q) begin
      if (bkpt_ack) begin
        bkpt_d  = 1'b0;
        cause_d = '0;
      end
    end else if (any_hit) begin
      bkpt_d  = 1'b1;
      cause_d = hits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkpt_q  <= 1'b0;
      cause_q <= '0;
      frz_q   <= 1'b0;
    end else begin
      frz_q <= freeze;
      if (flag_en) begin
        bkpt_q  <= bkpt_d;
        cause_q <= cause_d;
      end
    end
  end

  // R8
  bkpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_q && !bkpt_ack && !freeze) |=> (bkpt_q && $stable(cause_q)));

  // R9
  bkpt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_q && bkpt_ack) |=> (!bkpt_q && cause_q == '0));

  // R3
  cause_with_bkpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cause_q.upc) || $rose(cause_q.chan) || $rose(cause_q.svc)) |-> $rose(bkpt_q));

endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
  import dbg_bp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int UPC_W = 10,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             state_start,
  input  logic [UPC_W-1:0] seq_upc,
  input  logic [CH_W-1:0]  seq_chan,
  input  logic             chan_wr,
  input  logic [CH_W-1:0]  chan_wdata,
  input  logic [3:0]       svc_lat,
  input  logic             bkpt_ack,
  input  logic             freeze,
  output logic             bkpt_out,
  output logic             halt_req
);

  logic [EN_W-1:0]   ctrl_q;
  logic [UPC_W-1:0]  ubp_q;
  logic [CH_W-1:0]   cbp_q;
  cause_t            hits;
  cause_t            cause_q;
  logic              bkpt_q;
  logic              frz_q;
  logic [STAT_W-1:0] stat_flags;

  assign stat_flags = {bkpt_q, cause_q.upc, cause_q.chan, cause_q.svc, frz_q};

  dbg_bp_regs #(.DW(DW), .UPC_W(UPC_W), .CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .stat_flags (stat_flags),
    .ctrl_q     (ctrl_q),
    .ubp_q      (ubp_q),
    .cbp_q      (cbp_q),
    .reg_rdata  (reg_rdata)
  );

  dbg_bp_detect #(.UPC_W(UPC_W), .CH_W(CH_W)) u_detect (
    .ctrl_q      (ctrl_q),
    .ubp_q       (ubp_q),
    .cbp_q       (cbp_q),
    .state_start (state_start),
    .seq_upc     (seq_upc),
    .seq_chan    (seq_chan),
    .chan_wr     (chan_wr),
    .chan_wdata  (chan_wdata),
    .svc_lat     (svc_lat),
    .hits        (hits)
  );

  dbg_bp_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hits     (hits),
    .bkpt_ack (bkpt_ack),
    .freeze   (freeze),
    .bkpt_q   (bkpt_q),
    .cause_q  (cause_q),
    .frz_q    (frz_q)
  );

  assign bkpt_out = bkpt_q;
  assign halt_req = bkpt_q | frz_q;

  // R6
  upc_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q.upc) |-> $past(ctrl_q[EN_UPC]));

  // R6
  chan_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q.chan) |-> $past(ctrl_q[EN_CHAN]));

  // R10
  freeze_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (halt_req && !bkpt_out && cause_q == '0));

endmodule

// File: tb/test_dbg_break_unit.sv
`timescale 1ns/1ps
module test_dbg_break_unit;

  localparam int DW = 16, UPC_W = 10, CH_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_sel = 2'd3;
  logic [DW-1:0]    reg_wdata = '0;
  logic [DW-1:0]    reg_rdata;
  logic             state_start = 1'b0;
  logic [UPC_W-1:0] seq_upc = '0;
  logic [CH_W-1:0]  seq_chan = '0;
  logic             chan_wr = 1'b0;
  logic [CH_W-1:0]  chan_wdata = '0;
  logic [3:0]       svc_lat = '0;
  logic             bkpt_ack = 1'b0;
  logic             freeze = 1'b0;
  logic             bkpt_out, halt_req;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [5:0]       m_ctrl;
  logic [UPC_W-1:0] m_ubp;
  logic [CH_W-1:0]  m_cbp;
  logic m_bk, m_pc, m_ch, m_sv, m_fz;

  dbg_break_unit #(.DW(DW), .UPC_W(UPC_W), .CH_W(CH_W)) i_dbg_break_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .state_start(state_start),
    .seq_upc(seq_upc), .seq_chan(seq_chan), .chan_wr(chan_wr),
    .chan_wdata(chan_wdata), .svc_lat(svc_lat), .bkpt_ack(bkpt_ack),
    .freeze(freeze), .bkpt_out(bkpt_out), .halt_req(halt_req)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_status();
    return {8'h00, m_bk, m_pc, m_ch, m_sv, m_fz, 3'b000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic hp, hc, hs;
    hp = state_start && m_ctrl[5] && (seq_upc == m_ubp);
    hc = m_ctrl[4] && ((state_start && seq_chan == m_cbp) || (chan_wr && chan_wdata == m_cbp));
    hs = state_start && |(m_ctrl[3:0] & svc_lat);
    if (freeze) begin
      m_bk = 0; m_pc = 0; m_ch = 0; m_sv = 0;
    end else if (m_bk) begin
      if (bkpt_ack) begin m_bk = 0; m_pc = 0; m_ch = 0; m_sv = 0; end
    end else if (hp || hc || hs) begin
      m_bk = 1; m_pc = hp; m_ch = hc; m_sv = hs;
    end
    m_fz = freeze;
    if (reg_wr) begin
      case (reg_sel)
        2'd0: m_ctrl = reg_wdata[5:0];
        2'd1: m_ubp  = reg_wdata[UPC_W-1:0];
        2'd2: m_cbp  = reg_wdata[CH_W-1:0];
        default: ;
      endcase
    end
  endtask

  // one clock with the inputs currently driven; compare against the model
  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    reg_wr = 1'b0; reg_sel = 2'd3;
    state_start = 1'b0; chan_wr = 1'b0; bkpt_ack = 1'b0; svc_lat = '0;
    @(negedge clk);
    check("R2 status model", {16'h0, reg_rdata}, {16'h0, exp_status()});
    check("R11 halt model", {31'h0, halt_req}, {31'h0, m_bk | m_fz});
    check("R8 bkpt model", {31'h0, bkpt_out}, {31'h0, m_bk});
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    cyc();
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    reg_sel = s; #1; d = reg_rdata; reg_sel = 2'd3;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    m_ctrl = '0; m_ubp = '0; m_cbp = '0;
    m_bk = 0; m_pc = 0; m_ch = 0; m_sv = 0; m_fz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      check("R1 reg after reset", {16'h0, v}, 32'h0);
    end
    check("R1 bkpt_out", {31'h0, bkpt_out}, 32'h0);
    check("R1 halt_req", {31'h0, halt_req}, 32'h0);

    // R2 write/readback
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 ctrl mask", {16'h0, v}, 32'h003F);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R2 ubp mask", {16'h0, v}, 32'h03FF);
    wr(2'd1, 16'h0155); rd(2'd1, v); check("R2 ubp", {16'h0, v}, 32'h0155);
    wr(2'd2, 16'h0005); rd(2'd2, v); check("R2 cbp", {16'h0, v}, 32'h0005);
    wr(2'd3, 16'hFFFF); rd(2'd0, v); check("R2 status write inert", {16'h0, v}, 32'h003F);
    rd(2'd3, v); check("R2 status write inert", {16'h0, v}, 32'h0000);

    // R3 address compare
    wr(2'd0, 16'h0020);
    seq_upc = 10'h155; cyc();
    check("R3 no start no break", {31'h0, bkpt_out}, 32'h0);
    seq_upc = 10'h155; state_start = 1'b1; cyc();
    rd(2'd3, v); check("R3 upc break status", {16'h0, v}, 32'h00C0);
    check("R3 halt", {31'h0, halt_req}, 32'h1);
    // R8 hold with more hits
    wr(2'd0, 16'h003F);
    state_start = 1'b1; svc_lat = 4'hF; seq_chan = 4'h5; cyc();
    rd(2'd3, v); check("R8 held flags", {16'h0, v}, 32'h00C0);
    // R9 acknowledge
    bkpt_ack = 1'b1; cyc();
    rd(2'd3, v); check("R9 cleared", {16'h0, v}, 32'h0000);
    check("R9 halt drop", {31'h0, halt_req}, 32'h0);

    // R4 mid-state channel write
    wr(2'd0, 16'h0010);
    chan_wr = 1'b1; chan_wdata = 4'h5; seq_chan = 4'h0; cyc();
    rd(2'd3, v); check("R4 chan write break", {16'h0, v}, 32'h00A0);
    bkpt_ack = 1'b1; cyc();
    state_start = 1'b1; seq_chan = 4'h5; cyc();
    rd(2'd3, v); check("R4 chan start break", {16'h0, v}, 32'h00A0);
    bkpt_ack = 1'b1; cyc();

    // R5 service latches only at state start
    wr(2'd0, 16'h0008);
    svc_lat = 4'h8; cyc();
    rd(2'd3, v); check("R5 latch ignored off boundary", {16'h0, v}, 32'h0000);
    svc_lat = 4'h7; state_start = 1'b1; cyc();
    rd(2'd3, v); check("R5 other latches disabled", {16'h0, v}, 32'h0000);
    svc_lat = 4'h8; state_start = 1'b1; cyc();
    rd(2'd3, v); check("R5 latch break", {16'h0, v}, 32'h0090);
    bkpt_ack = 1'b1; cyc();

    // R6 all disabled
    wr(2'd0, 16'h0000);
    state_start = 1'b1; seq_upc = 10'h155; seq_chan = 4'h5; svc_lat = 4'hF;
    chan_wr = 1'b1; chan_wdata = 4'h5; cyc();
    rd(2'd3, v); check("R6 disabled no break", {16'h0, v}, 32'h0000);

    // R7 all causes together
    wr(2'd0, 16'h003F);
    state_start = 1'b1; seq_upc = 10'h155; seq_chan = 4'h5; svc_lat = 4'h1; cyc();
    rd(2'd3, v); check("R7 all causes", {16'h0, v}, 32'h00F0);

    // R10 freeze overrides breakpoint
    freeze = 1'b1; cyc();
    rd(2'd3, v); check("R10 freeze status", {16'h0, v}, 32'h0008);
    check("R10 freeze halt", {31'h0, halt_req}, 32'h1);
    check("R10 freeze clears bkpt", {31'h0, bkpt_out}, 32'h0);
    state_start = 1'b1; svc_lat = 4'hF; cyc();
    rd(2'd3, v); check("R10 no break in freeze", {16'h0, v}, 32'h0008);
    freeze = 1'b0; cyc();
    rd(2'd3, v); check("R10 freeze released", {16'h0, v}, 32'h0000);
    check("R11 halt after freeze", {31'h0, halt_req}, 32'h0);

    // random mix checked against the model
    wr(2'd1, 16'h0002); wr(2'd2, 16'h0001); wr(2'd0, 16'h003F);
    for (int i = 0; i < 3000; i++) begin
      state_start = ($urandom % 3) == 0;
      seq_upc     = 10'($urandom % 4);
      seq_chan    = 4'($urandom % 4);
      chan_wr     = ($urandom % 5) == 0;
      chan_wdata  = 4'($urandom % 4);
      svc_lat     = 4'($urandom & $urandom);
      bkpt_ack    = ($urandom % 4) == 0;
      if (($urandom % 40) == 0) freeze = ~freeze;
      if (($urandom % 30) == 0) begin
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'($urandom);
      end
      cyc();
    end
    freeze = 1'b0; cyc();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule